// File: doc/BRIEF.md
# Dual Down-Counting Timer Unit

The block holds two independent 32-bit down-counters behind a small word-addressed register bus, along with a shared interrupt status, mask and acknowledge set. Each channel has a reload value and a control word. The control word holds an operation code (load, hold or run) and a tick-source selector. While a channel runs, it counts down once for each pulse of its chosen tick enable. When it is at zero, the next tick reloads it and raises that channel's status bit, so the channel repeats its period without further writes.

Clock generation lies outside the block. Four tick sources arrive as single-cycle enables, and a separate enable drives a read-only free-running time counter. One registered, level-sensitive interrupt line is high while any status bit that is both set and unmasked remains. Software reads the raw status and the masked status from separate offsets and clears bits by writing ones to the acknowledge offset.

Top module: `dual_timer_unit`

## Requirements
- R1: After synchronous reset: `irq` is 0; raw status, mask, both counts, both reload values and the time counter are 0; both channels are stopped with selector 0.
- R2: Byte offsets are as follows. Channel n (n = 0, 1) has reload at n*0x10+0x0, current count (read) at n*0x10+0x4 and control at n*0x10+0x8. Time is at 0x38, mask at 0x48, acknowledge at 0x4C, raw status at 0x50 and masked status at 0x54. Reload, control and acknowledge read as 0.
- R3: Control bits [1:0] are the operation code. Code 0 copies the reload value into the count and leaves the run state unchanged. Code 1 stops the channel and code 2 starts it. A control write with code 3 is ignored entirely, so neither the selector nor the run state changes.
- R4: Control bits [4:2] select the tick source. Values 4, 5, 6 and 7 pick `tick_src[0]` to `tick_src[3]`. Any other value means the channel never counts.
- R5: On each selected tick, a running channel with a nonzero count decrements by 1. A running channel at 0 reloads from its reload value instead, so one period lasts reload+1 ticks.
- R6: A reload on expiry sets raw status bit 0 for channel 0 or bit 1 for channel 1.
- R7: A write to the acknowledge offset clears every raw status bit written as 1 (bits [1:0]). If the same bit expires in the same cycle, it stays set.
- R8: Mask is bits [1:0] of the mask offset. Masked status equals raw status AND mask. `irq` is a register equal to the OR of the masked status bits and reflects the state of the same clock edge.
- R9: The time counter adds 1 on each cycle with `time_tick` high. Writes to its offset have no effect.
- R10: A read of an unmapped offset returns 0, and a write to one changes nothing. `bus_rdata` is loaded on the edge where `bus_rd` is high and holds its value until the next read.
- R11: A channel does not count in a cycle in which its control offset is written, whatever the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_src | input | 4 | Selectable count tick enables |
| time_tick | input | 1 | Time counter tick enable |
| irq | output | 1 | Level interrupt from masked status |

## Verification
A count register that is wrong inside the block shows up on the next read of its data offset. If it misses a reload, the status bit and `irq` go wrong one tick later, at the edge where expiry was due. A wrong status or mask register moves `irq` on the same edge. The reference model compares `irq` on every cycle and compares each read result, so a fault becomes visible within the cycle after it occurs, once it reaches a port. The stimulus covers an ack that lands on an expiry, ticks that coincide with control writes, and ticks on sources that are not selected.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int NUM_CH    = 2;
  localparam int NUM_SRC   = 4;
  localparam int SEL_W     = 3;
  localparam int CH_STRIDE = 16;
  localparam int OFF_RELOAD = 0;
  localparam int OFF_COUNT  = 4;
  localparam int OFF_CTRL   = 8;
  localparam int OFF_TIME   = 56;
  localparam int OFF_MASK   = 72;
  localparam int OFF_ACK    = 76;
  localparam int OFF_STAT   = 80;
  localparam int OFF_MSTAT  = 84;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } op_e;
endpackage

// File: rtl/dtu_channel.sv
module dtu_channel
  import dtu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reload_wr,
  input  logic                ctrl_wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0]  tick_src,
  output logic [DATA_W-1:0]   count_o,
  output logic                running_o,
  output logic                expire_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [DATA_W-1:0] reload_q, count_q;
  logic [SEL_W-1:0]  sel_q;
  logic              run_q;
  logic              tick_hit;
  op_e               op;

  assign op       = op_e'(wdata[1:0]);
  assign tick_hit = sel_q[SEL_W-1] & tick_src[sel_q[IDX_W-1:0]];
  assign expire_o = run_q & tick_hit & ~ctrl_wr & (count_q == '0);
  assign count_o  = count_q;
  assign running_o = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= '0;
      sel_q    <= '0;
      run_q    <= 1'b0;
    end else begin
      if (reload_wr) reload_q <= wdata;
      if (ctrl_wr && op != OP_BAD) begin
        sel_q <= wdata[SEL_W+1:2];
        case (op)
          OP_LOAD: count_q <= reload_q;
          OP_HOLD: run_q   <= 1'b0;
          OP_RUN:  run_q   <= 1'b1;
          default: ;
        endcase
      end else if (run_q && tick_hit && !ctrl_wr) begin
        count_q <= (count_q == '0) ? reload_q : count_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dtu_irq.sv
module dtu_irq
  import dtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] expire,
  input  logic              mask_wr,
  input  logic              ack_wr,
  input  logic [NUM_CH-1:0] wbits,
  output logic [NUM_CH-1:0] status_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] status_q, mask_q, status_n, mask_n, clr;

  assign clr      = ack_wr ? wbits : '0;
  assign status_n = (status_q & ~clr) | expire;
  assign mask_n   = mask_wr ? wbits : mask_q;
  assign status_o = status_q;
  assign mask_o   = mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_q <= status_n;
      mask_q   <= mask_n;
      irq_o    <= |(status_n & mask_n);
    end
  end
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic               time_tick,
  output logic               irq
);
  logic [DATA_W-1:0] count  [NUM_CH];
  logic [NUM_CH-1:0] running, expire, reload_wr, ctrl_wr;
  logic [NUM_CH-1:0] status, mask;
  logic [DATA_W-1:0] time_q;
  logic              mask_wr, ack_wr;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign reload_wr[i] = bus_wr && bus_addr == ADDR_W'(i*CH_STRIDE + OFF_RELOAD);
      assign ctrl_wr[i]   = bus_wr && bus_addr == ADDR_W'(i*CH_STRIDE + OFF_CTRL);
      dtu_channel #(.DATA_W(DATA_W)) u_ch (
        .clk       (clk),
        .rst       (rst),
        .reload_wr (reload_wr[i]),
        .ctrl_wr   (ctrl_wr[i]),
        .wdata     (bus_wdata),
        .tick_src  (tick_src),
        .count_o   (count[i]),
        .running_o (running[i]),
        .expire_o  (expire[i])
      );
    end
  endgenerate

  assign mask_wr = bus_wr && bus_addr == ADDR_W'(OFF_MASK);
  assign ack_wr  = bus_wr && bus_addr == ADDR_W'(OFF_ACK);

  dtu_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .expire   (expire),
    .mask_wr  (mask_wr),
    .ack_wr   (ack_wr),
    .wbits    (bus_wdata[NUM_CH-1:0]),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) time_q <= '0;
    else if (time_tick) time_q <= time_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFF_COUNT):             bus_rdata <= count[0];
        ADDR_W'(CH_STRIDE + OFF_COUNT): bus_rdata <= count[1];
        ADDR_W'(OFF_TIME):              bus_rdata <= time_q;
        ADDR_W'(OFF_MASK):              bus_rdata <= DATA_W'(mask);
        ADDR_W'(OFF_STAT):              bus_rdata <= DATA_W'(status);
        ADDR_W'(OFF_MSTAT):             bus_rdata <= DATA_W'(status & mask);
        default:                        bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dtu_checker.sv
module dtu_checker (
  input logic        clk,
  input logic        rst,
  input logic        irq,
  input logic [1:0]  status,
  input logic [1:0]  mask,
  input logic [1:0]  expire,
  input logic        ack_wr,
  input logic [31:0] wdata,
  input logic        time_tick,
  input logic [31:0] time_q,
  input logic        run0,
  input logic        ctrl_wr0,
  input logic [31:0] count0
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq && status == 2'b00 && mask == 2'b00));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!run0 && !ctrl_wr0) |=> $stable(count0));

  p_expiry_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (expire != 2'b00) |=> ((status & $past(expire)) == $past(expire)));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && wdata[0] && !expire[0]) |=> !status[0]);

  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq == |(status & mask));

  p_time_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !time_tick |=> $stable(time_q));
endmodule

bind dual_timer_unit dtu_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .status    (status),
  .mask      (mask),
  .expire    (expire),
  .ack_wr    (ack_wr),
  .wdata     (bus_wdata),
  .time_tick (time_tick),
  .time_q    (time_q),
  .run0      (running[0]),
  .ctrl_wr0  (ctrl_wr[0]),
  .count0    (count[0])
);

// File: tb/tb_dual_timer_unit.sv
module tb_dual_timer_unit;
  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_src = 0;
  logic        time_tick = 0;
  logic        irq;
  logic        time_en = 1;

  int tests = 0, fails = 0, cyc = 0;

  dual_timer_unit dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src),
    .time_tick(time_tick), .irq(irq)
  );

  always #4 clk = ~clk;

  // reference model state
  logic [31:0] m_reload [2];
  logic [31:0] m_count  [2];
  logic [2:0]  m_sel    [2];
  logic        m_run    [2];
  logic [1:0]  m_status, m_mask;
  logic        m_irq;
  logic [31:0] m_time, m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_reload[c] = 0; m_count[c] = 0; m_sel[c] = 0; m_run[c] = 0;
      end
      m_status = 0; m_mask = 0; m_irq = 0; m_time = 0; m_rdata = 0;
    end else begin
      logic [1:0] ex, ack;
      if (bus_rd) begin
        case (bus_addr)
          8'h04: m_rdata = m_count[0];
          8'h14: m_rdata = m_count[1];
          8'h38: m_rdata = m_time;
          8'h48: m_rdata = {30'd0, m_mask};
          8'h50: m_rdata = {30'd0, m_status};
          8'h54: m_rdata = {30'd0, m_status & m_mask};
          default: m_rdata = 0;
        endcase
      end
      ex = 0;
      for (int c = 0; c < 2; c++) begin
        bit cw, rw, tk;
        cw = bus_wr && bus_addr == 8'(c*16 + 8);
        rw = bus_wr && bus_addr == 8'(c*16);
        tk = m_sel[c] >= 4 && tick_src[m_sel[c] - 4];
        if (cw && bus_wdata[1:0] != 2'd3) begin
          m_sel[c] = bus_wdata[4:2];
          if (bus_wdata[1:0] == 0) m_count[c] = m_reload[c];
          else if (bus_wdata[1:0] == 1) m_run[c] = 0;
          else m_run[c] = 1;
        end else if (!cw && m_run[c] && tk) begin
          if (m_count[c] == 0) begin
            ex[c] = 1;
            m_count[c] = m_reload[c];
          end else m_count[c] = m_count[c] - 1;
        end
        if (rw) m_reload[c] = bus_wdata;
      end
      ack = (bus_wr && bus_addr == 8'h4C) ? bus_wdata[1:0] : 2'b00;
      m_status = (m_status & ~ack) | ex;
      if (bus_wr && bus_addr == 8'h48) m_mask = bus_wdata[1:0];
      m_irq = |(m_status & m_mask);
      if (time_tick) m_time = m_time + 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R8 irq, R2 read data)
  always @(negedge clk) begin
    if (!rst) begin
      check("R8 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      check("R2 rdata vs model", bus_rdata, m_rdata);
    end
  end

  // time tick stimulus
  initial begin
    forever begin
      @(negedge clk);
      time_tick = time_en && (cyc % 3 == 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic ticks(input logic [3:0] m, input int n);
    @(negedge clk);
    tick_src = m;
    repeat (n) @(negedge clk);
    tick_src = 0;
  endtask

  initial begin
    logic [31:0] v, t1;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 irq after reset", {31'd0, irq}, 0);
    rd(8'h50, v); check("R1 status after reset", v, 0);
    rd(8'h48, v); check("R1 mask after reset", v, 0);
    rd(8'h04, v); check("R1 count0 after reset", v, 0);

    // channel 0: reload 3, load, run on source 0
    wr(8'h00, 3);
    wr(8'h08, 32'h10);
    rd(8'h04, v); check("R3 load copies reload", v, 3);
    rd(8'h00, v); check("R2 reload reads zero", v, 0);
    wr(8'h08, 32'h12);
    ticks(4'b0010, 5);
    rd(8'h04, v); check("R4 unselected source ignored", v, 3);
    ticks(4'b0001, 2);
    rd(8'h04, v); check("R5 decrement per tick", v, 1);
    ticks(4'b0001, 2);
    rd(8'h04, v); check("R5 reload on expiry", v, 3);
    rd(8'h50, v); check("R6 timer0 sets bit0", v, 1);
    check("R8 irq low while masked", {31'd0, irq}, 0);
    wr(8'h48, 3);
    check("R8 irq after unmask", {31'd0, irq}, 1);
    rd(8'h54, v); check("R8 masked status", v, 1);
    wr(8'h4C, 1);
    check("R7 irq after ack", {31'd0, irq}, 0);
    rd(8'h50, v); check("R7 ack clears bit0", v, 0);
    rd(8'h4C, v); check("R7 ack reads zero", v, 0);

    // hold and illegal code
    wr(8'h08, 32'h11);
    ticks(4'b0001, 5);
    rd(8'h04, v); check("R3 hold stops count", v, 3);
    wr(8'h08, 32'h13);
    ticks(4'b0001, 5);
    rd(8'h04, v); check("R3 code 3 ignored", v, 3);
    wr(8'h08, 32'h02);
    ticks(4'b1111, 5);
    rd(8'h04, v); check("R4 selector 0 never counts", v, 3);

    // expiry colliding with ack
    wr(8'h00, 0);
    wr(8'h08, 32'h10);
    wr(8'h08, 32'h12);
    @(negedge clk); tick_src = 4'b0001;
    wr(8'h4C, 1);
    rd(8'h50, v); check("R7 expiry wins over ack", v[0], 1);
    @(negedge clk); tick_src = 0;
    wr(8'h4C, 1);
    rd(8'h50, v); check("R7 ack clears without expiry", v, 0);

    // R11: control writes during ticks do not count
    wr(8'h08, 32'h11);
    wr(8'h00, 5);
    wr(8'h08, 32'h10);
    @(negedge clk);
    tick_src = 4'b0001; bus_wr = 1; bus_addr = 8'h08; bus_wdata = 32'h12;
    @(negedge clk);
    bus_wdata = 32'h11;
    @(negedge clk);
    bus_wr = 0; tick_src = 0;
    rd(8'h04, v); check("R11 no count on control write", v, 5);

    // channel 1 on source 3
    wr(8'h10, 1);
    wr(8'h18, 32'h1C);
    wr(8'h18, 32'h1E);
    ticks(4'b1000, 2);
    rd(8'h50, v); check("R6 timer1 sets bit1", v, 2);
    rd(8'h14, v); check("R5 timer1 reloaded", v, 1);
    check("R8 irq from timer1", {31'd0, irq}, 1);
    wr(8'h48, 1);
    check("R8 irq after masking bit1", {31'd0, irq}, 0);
    rd(8'h54, v); check("R8 masked status zero", v, 0);

    // time counter
    time_en = 0;
    repeat (2) @(negedge clk);
    rd(8'h38, t1);
    wr(8'h38, 32'hDEAD_BEEF);
    rd(8'h38, v); check("R9 time write ignored", v, t1);
    time_en = 1;
    repeat (12) @(negedge clk);
    rd(8'h38, v); check("R9 time advances", {31'd0, v != t1}, 1);

    // unmapped
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R10 unmapped read zero", v, 0);
    rd(8'h04, v); check("R10 unmapped write no effect", v, 5);
    rd(8'h48, v); check("R10 mask untouched", v, 1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule